// File: doc/BRIEF.md
# Width-Switchable Accumulator Unit

This block is the accumulator datapath of an 8/16-bit processor core. It holds a 16-bit accumulator and the N, Z and C condition flags. A single width input chooses how each operation treats the accumulator. With the width input high, the accumulator is one 16-bit register. With it low, the accumulator is two separate byte registers: a low byte that operations act on, and a high byte that they must not disturb.

The surrounding core presents one operation code per clock cycle, together with the width flag, a carry input and load data. The unit supports six operations: load, increment, decrement, rotate right through carry, byte exchange and carry set-up. The exchange operation swaps the two bytes in either mode, which is the only way to reach the hidden high byte in narrow mode. Results and flags are registered, so they appear on the outputs one cycle after the operation is presented. The reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `acc_width_unit`

## Requirements
- R1: While reset is active, and after it is released until the first operation, `acc` is 0x0000 and `flag_n`, `flag_z` and `flag_c` are 0.
- R2: Operation code 1 (load) writes `din` to the whole accumulator when `wide`=1. When `wide`=0 it writes `din[7:0]` to the low byte only.
- R3: When `wide`=0, load, increment (code 2), decrement (code 3) and rotate (code 4) leave `acc[15:8]` unchanged.
- R4: Increment and decrement wrap at the selected width. With `wide`=0, incrementing a low byte of 0xFF gives 0x00 and does not carry into the high byte. With `wide`=1, incrementing 0xFFFF gives 0x0000.
- R5: Rotate right (code 4) moves the old C into bit 7 when `wide`=0, or into bit 15 when `wide`=1, and loads old bit 0 into C.
- R6: After codes 1 to 5, `flag_n` equals bit 7 of the result when `wide`=0, or bit 15 when `wide`=1.
- R7: After codes 1 to 5, `flag_z` is 1 exactly when the selected-width result is zero. With `wide`=0, only the low byte is tested.
- R8: Load, increment, decrement and exchange leave `flag_c` unchanged.
- R9: Exchange (code 5) swaps `acc[15:8]` and `acc[7:0]` in both modes.
- R10: Code 6 copies `carry_in` into `flag_c` and leaves `acc`, `flag_n` and `flag_z` unchanged.
- R11: Code 0 (idle) and the reserved code 7 change neither `acc` nor any flag.
- R12: Every result and flag change appears on the outputs at the first rising clock edge after the operation is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation code: 0 idle, 1 load, 2 increment, 3 decrement, 4 rotate right, 5 exchange, 6 set carry, 7 reserved |
| wide | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit operation |
| carry_in | input | 1 | Value copied into C by code 6 |
| din | input | 16 | Load data |
| acc | output | 16 | Accumulator contents |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bound checker tests several relations on every cycle. It confirms that the high byte holds still under narrow data operations. It confirms that C is kept by the operations that must not touch it. It also checks the exchange result, the rotate's carry-out, the width-dependent positions of N and Z, and that idle and reserved codes change no state. Only the bench scenarios can show other behaviours. These are the exact wrap values at 0xFF and 0xFFFF, the carry landing in bit 7 rather than bit 15, narrow loads ignoring `din[15:8]`, and long mixed sequences in which hidden high-byte contents survive many narrow operations and are later brought out by an exchange.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_LOAD = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_ROR  = 3'd4,
    OP_SWAP = 3'd5,
    OP_SETC = 3'd6,
    OP_RSVD = 3'd7
  } acc_op_e;

  // Operations whose result is written back to the accumulator.
  function automatic logic op_writes_acc(acc_op_e o);
    return (o == OP_LOAD) || (o == OP_INC) || (o == OP_DEC) ||
           (o == OP_ROR)  || (o == OP_SWAP);
  endfunction

  // Operations that write the carry flag.
  function automatic logic op_writes_c(acc_op_e o);
    return (o == OP_ROR) || (o == OP_SETC);
  endfunction

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/acc_lane_alu.sv
module acc_lane_alu
  import acc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NLANES = 2,
  localparam int ACC_W = BYTE_W * NLANES
) (
  input  acc_op_e           op_i,
  input  logic              wide_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [ACC_W-1:0]  din_i,
  input  logic              c_i,
  output logic [ACC_W-1:0]  res_o,
  output logic [NLANES-1:0] lane_we_o,
  output logic              c_shift_o
);

  localparam logic [BYTE_W-1:0] ONE_B = BYTE_W'(1);
  localparam logic [ACC_W-1:0]  ONE_W = ACC_W'(1);

  logic [BYTE_W-1:0] lo;
  logic [ACC_W-BYTE_W-1:0] hi;
  logic [BYTE_W-1:0] lo_new;
  logic [ACC_W-1:0]  wide_new;
  logic [ACC_W-1:0]  swapped;

  assign lo = acc_i[BYTE_W-1:0];
  assign hi = acc_i[ACC_W-1:BYTE_W];
  assign swapped = {lo, hi};

  // Narrow-width result for the low lane.
  always_comb begin
    unique case (op_i)
      OP_LOAD: lo_new = din_i[BYTE_W-1:0];
      OP_INC:  lo_new = lo + ONE_B;
      OP_DEC:  lo_new = lo - ONE_B;
      OP_ROR:  lo_new = {c_i, lo[BYTE_W-1:1]};
      default: lo_new = lo;
    endcase
  end

  // Full-width result.
  always_comb begin
    unique case (op_i)
      OP_LOAD: wide_new = din_i;
      OP_INC:  wide_new = acc_i + ONE_W;
      OP_DEC:  wide_new = acc_i - ONE_W;
      OP_ROR:  wide_new = {c_i, acc_i[ACC_W-1:1]};
      default: wide_new = acc_i;
    endcase
  end

  // Exchange ignores the width. Narrow data ops write lane 0 only.
  always_comb begin
    c_shift_o = acc_i[0];
    if (op_i == OP_SWAP) begin
      res_o     = swapped;
      lane_we_o = '1;
    end else if (wide_i) begin
      res_o     = wide_new;
      lane_we_o = op_writes_acc(op_i) ? '1 : '0;
    end else begin
      res_o     = {hi, lo_new};
      lane_we_o = op_writes_acc(op_i) ? NLANES'(1) : '0;
    end
  end

endmodule

// File: rtl/acc_flag_eval.sv
module acc_flag_eval #(
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic [ACC_W-1:0] val_i,
  input  logic             wide_i,
  output logic             n_o,
  output logic             z_o
);

  logic z_narrow;
  logic z_wide;

  assign z_narrow = (val_i[BYTE_W-1:0] == '0);
  assign z_wide   = (val_i == '0);

  always_comb begin
    if (wide_i) begin
      n_o = val_i[ACC_W-1];
      z_o = z_wide;
    end else begin
      n_o = val_i[BYTE_W-1];
      z_o = z_narrow;
    end
  end

endmodule

// File: rtl/acc_width_unit.sv
module acc_width_unit
  import acc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NLANES = 2,
  localparam int ACC_W = BYTE_W * NLANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic             wide,
  input  logic             carry_in,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] acc,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c
);

  logic rst_sync_n;
  acc_op_e op_e;

  logic [ACC_W-1:0]  acc_q, acc_d;
  logic              n_q, n_d, z_q, z_d, c_q, c_d;
  logic              acc_en, nz_en, c_en;

  logic [ACC_W-1:0]  alu_res;
  logic [NLANES-1:0] lane_we;
  logic              c_shift;
  logic              n_eval, z_eval;

  assign op_e = acc_op_e'(op);

  acc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acc_lane_alu #(.BYTE_W(BYTE_W), .NLANES(NLANES)) u_alu (
    .op_i      (op_e),
    .wide_i    (wide),
    .acc_i     (acc_q),
    .din_i     (din),
    .c_i       (c_q),
    .res_o     (alu_res),
    .lane_we_o (lane_we),
    .c_shift_o (c_shift)
  );

  // Per-lane merge of the new value.
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign acc_d[g*BYTE_W +: BYTE_W] =
      lane_we[g] ? alu_res[g*BYTE_W +: BYTE_W] : acc_q[g*BYTE_W +: BYTE_W];
  end

  acc_flag_eval #(.BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_flags (
    .val_i  (acc_d),
    .wide_i (wide),
    .n_o    (n_eval),
    .z_o    (z_eval)
  );

  // Next-state and enable logic.
  always_comb begin
    acc_en = op_writes_acc(op_e);
    nz_en  = op_writes_acc(op_e);
    c_en   = op_writes_c(op_e);
    n_d    = n_eval;
    z_d    = z_eval;
    c_d    = (op_e == OP_SETC) ? carry_in : c_shift;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (nz_en) begin
        n_q <= n_d;
        z_q <= z_d;
      end
      if (c_en) c_q <= c_d;
    end
  end

  assign acc    = acc_q;
  assign flag_n = n_q;
  assign flag_z = z_q;
  assign flag_c = c_q;

endmodule

// File: rtl/acc_width_unit_chk.sv
module acc_width_unit_chk #(
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [2:0]       op,
  input logic             wide,
  input logic [ACC_W-1:0] acc,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c
);

  logic data_op;
  logic narrow_keep;
  logic c_keep;
  logic idle_op;

  assign data_op     = (op >= 3'd1) && (op <= 3'd5);
  assign narrow_keep = !wide && (op >= 3'd1) && (op <= 3'd4);
  assign c_keep      = (op == 3'd1) || (op == 3'd2) || (op == 3'd3) || (op == 3'd5);
  assign idle_op     = (op == 3'd0) || (op == 3'd7);

  a_r3_high_byte_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    narrow_keep |=> acc[ACC_W-1:BYTE_W] == $past(acc[ACC_W-1:BYTE_W]));

  a_r8_carry_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    c_keep |=> $stable(flag_c));

  a_r9_bytes_swapped: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == 3'd5) |=> acc == {$past(acc[BYTE_W-1:0]), $past(acc[ACC_W-1:BYTE_W])});

  a_r5_rotate_carry_out: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == 3'd4) |=> flag_c == $past(acc[0]));

  a_r6_negative_position: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_op |=> flag_n == ($past(wide) ? acc[ACC_W-1] : acc[BYTE_W-1]));

  a_r7_zero_width: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_op |=> flag_z == ($past(wide) ? (acc == '0) : (acc[BYTE_W-1:0] == '0)));

  a_r11_idle_no_change: assert property (@(posedge clk) disable iff (!rst_sync_n)
    idle_op |=> $stable(acc) && $stable(flag_n) && $stable(flag_z) && $stable(flag_c));

  a_r10_setc_acc_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == 3'd6) |=> $stable(acc) && $stable(flag_n) && $stable(flag_z));

endmodule

bind acc_width_unit acc_width_unit_chk #(.BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op         (op),
  .wide       (wide),
  .acc        (acc),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_c     (flag_c)
);

// File: tb/acc_width_unit_bench.sv
module acc_width_unit_bench;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op;
  logic        wide;
  logic        carry_in;
  logic [15:0] din;
  logic [15:0] acc;
  logic        flag_n, flag_z, flag_c;

  int checks;
  int failures;
  bit done;

  logic [15:0] m_acc;
  logic        m_n, m_z, m_c;

  acc_width_unit u_acc_width_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .wide     (wide),
    .carry_in (carry_in),
    .din      (din),
    .acc      (acc),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_c   (flag_c)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic model(input logic [2:0] o, input logic w, input logic [15:0] d,
                       input logic ci);
    logic b;
    case (o)
      3'd1: if (w) m_acc = d; else m_acc[7:0] = d[7:0];
      3'd2: if (w) m_acc = m_acc + 16'd1; else m_acc[7:0] = m_acc[7:0] + 8'd1;
      3'd3: if (w) m_acc = m_acc - 16'd1; else m_acc[7:0] = m_acc[7:0] - 8'd1;
      3'd4: begin
        b = m_acc[0];
        if (w) m_acc = {m_c, m_acc[15:1]};
        else   m_acc[7:0] = {m_c, m_acc[7:1]};
        m_c = b;
      end
      3'd5: m_acc = {m_acc[7:0], m_acc[15:8]};
      3'd6: m_c = ci;
      default: ;
    endcase
    if (o >= 3'd1 && o <= 3'd5) begin
      m_n = w ? m_acc[15] : m_acc[7];
      m_z = w ? (m_acc == 16'd0) : (m_acc[7:0] == 8'd0);
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (acc !== m_acc || flag_n !== m_n || flag_z !== m_z || flag_c !== m_c) begin
      failures++;
      $display("FAIL %s: acc=%h n=%b z=%b c=%b expected acc=%h n=%b z=%b c=%b",
               tag, acc, flag_n, flag_z, flag_c, m_acc, m_n, m_z, m_c);
    end
  endtask

  // Called at a falling edge; result is sampled at the next falling edge (R12).
  task automatic do_op(input logic [2:0] o, input logic w, input logic [15:0] d,
                       input logic ci, input string tag);
    op = o; wide = w; din = d; carry_in = ci;
    @(posedge clk);
    model(o, w, d, ci);
    @(negedge clk);
    op = 3'd0;
    compare(tag);
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd1: return "R2";
      3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    checks = 0; failures = 0; done = 0;
    op = 3'd0; wide = 1'b0; carry_in = 1'b0; din = 16'h0;
    m_acc = 16'h0; m_n = 0; m_z = 0; m_c = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1 after release");

    do_op(3'd1, 1'b1, 16'hAB12, 1'b0, "R2 wide load");
    do_op(3'd1, 1'b0, 16'h7734, 1'b0, "R2 R3 narrow load keeps high");
    do_op(3'd1, 1'b1, 16'h12FF, 1'b0, "R2 wide load");
    do_op(3'd2, 1'b0, 16'h0, 1'b0, "R4 R7 narrow inc wraps, high kept");
    do_op(3'd3, 1'b0, 16'h0, 1'b0, "R4 R6 narrow dec wraps to FF");
    do_op(3'd1, 1'b1, 16'hFFFF, 1'b0, "R2 R6 wide load negative");
    do_op(3'd2, 1'b1, 16'h0, 1'b0, "R4 R7 wide inc wraps to zero");
    do_op(3'd6, 1'b0, 16'h0, 1'b1, "R10 set carry");
    do_op(3'd1, 1'b0, 16'h0002, 1'b0, "R8 load keeps carry");
    do_op(3'd4, 1'b0, 16'h0, 1'b0, "R5 narrow rotate into bit 7");
    do_op(3'd6, 1'b1, 16'h0, 1'b1, "R10 set carry");
    do_op(3'd1, 1'b1, 16'h0003, 1'b0, "R2 wide load");
    do_op(3'd4, 1'b1, 16'h0, 1'b0, "R5 R6 wide rotate into bit 15");
    do_op(3'd1, 1'b1, 16'h5A00, 1'b0, "R2 wide load");
    do_op(3'd5, 1'b0, 16'h0, 1'b0, "R9 narrow exchange");
    do_op(3'd5, 1'b1, 16'h0, 1'b0, "R9 R7 wide exchange");
    do_op(3'd0, 1'b1, 16'hFFFF, 1'b1, "R11 idle");
    do_op(3'd7, 1'b0, 16'hFFFF, 1'b0, "R11 reserved code");

    seed_dummy = $urandom(32'd24680);
    for (int i = 0; i < 600; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      do_op(o, 1'($urandom_range(0, 1)), 16'($urandom), 1'($urandom_range(0, 1)),
            tag_of(o));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule